// File: doc/BRIEF.md
# Store Write Buffer with Load Forwarding

This block sits between a write-through first-level data cache and the next memory level. Every store the processor issues is placed in a small in-order queue together with its word address, data and byte enables, so the processor does not wait for the slower level to take the write. The oldest pending store is offered on a downstream valid/ready port and leaves the queue when that handshake completes.

Each load presents its word address and the data word read from the cache in the same cycle. The buffer compares the address against all pending stores at once and returns a merged word without adding a cycle. For each byte lane, the youngest pending store that writes that lane supplies it. Lanes that no pending store covers come from the cache. Two flags tell the load pipeline what happened. One says all lanes came from the buffer. The other says only some lanes matched, in which case the load must wait until the buffer drains.

Top module: `store_wbuf`

## Requirements
- R1: Out of reset the buffer is empty: `dnValid` is 0, `stReady` is 1, and loads see the cache data with both forwarding flags low.
- R2: `stReady` is low exactly when `DEPTH` stores are pending. A store offered while `stReady` is low is not taken.
- R3: Pending stores leave in the order they were accepted. The oldest one is shown on `dnAddr`/`dnData`/`dnBe` while `dnValid` is high, held steady while `dnReady` is low, and removed on the cycle `dnValid` and `dnReady` are both high.
- R4: A store accepted in the same cycle as a drain handshake leaves the number of pending stores unchanged.
- R5: A load whose address matches no pending store returns `cacheData` on `ldData`, with `ldFwd` and `ldPartial` low, in the same cycle the address is presented.
- R6: Each byte lane `ldData[8*b+7:8*b]` that some pending store with the same address writes (its `be[b]` is 1) carries that store's byte instead of the cache byte. `ldFwd` is 1 when all four lanes are covered in this way.
- R7: When several pending stores to the same address write the same lane, the most recently accepted one supplies that lane.
- R8: When at least one lane but not every lane is covered, `ldPartial` is 1 and `ldFwd` is 0. The uncovered lanes show the cache bytes. `ldFwd` and `ldPartial` are never high together.
- R9: A store that is still pending forwards, including during the cycle in which it drains. After the drain handshake it no longer affects loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Processor offers a store |
| stAddr | input | ADDR_W | Word address of the store |
| stData | input | DATA_W | Store data |
| stBe | input | DATA_W/8 | Store byte enables |
| stReady | output | 1 | Buffer can take a store this cycle |
| dnValid | output | 1 | Oldest pending store is offered downstream |
| dnAddr | output | ADDR_W | Address of the oldest pending store |
| dnData | output | DATA_W | Data of the oldest pending store |
| dnBe | output | DATA_W/8 | Byte enables of the oldest pending store |
| dnReady | input | 1 | Next level takes the offered store |
| ldAddr | input | ADDR_W | Word address of the load being looked up |
| cacheData | input | DATA_W | Word read from the cache for this load |
| ldData | output | DATA_W | Merged load data |
| ldFwd | output | 1 | Every lane came from the buffer |
| ldPartial | output | 1 | Some but not all lanes matched; the load must wait |

## Verification
A wrong pointer or occupancy count shows up on the downstream port within one handshake: an entry is repeated, skipped or out of order, or `stReady` drops one store early or late. A wrong entry age or a wrong validity window shows up in the same cycle as a load. The symptom is a lane taken from an older store, from a store already drained, or from the cache when it should come from the buffer. The bench uses a small configuration and keeps its own queue model, so any divergence is caught in the cycle it first appears on a port.

// File: rtl/store_wbuf_pkg.sv
package store_wbuf_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;   // write the offered store into the tail slot
    logic pop;    // head entry handed downstream this cycle
  } wbufStrobe_t;
endpackage

// File: rtl/store_wbuf_ctrl.sv
module store_wbuf_ctrl
  import store_wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             dnReady,
  output logic             stReady,
  output logic             dnValid,
  output wbufStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic isFull;

  assign isFull       = (count == FULL_CNT);
  assign stReady      = !isFull;
  assign dnValid      = (count != '0);
  assign strobe.push  = stValid && stReady;
  assign strobe.pop   = dnValid && dnReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      unique case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/store_wbuf_dp.sv
module store_wbuf_dp
  import store_wbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BYTES = DATA_W / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbufStrobe_t       strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BYTES-1:0]  stBe,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnData,
  output logic [BYTES-1:0]  dnBe,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] cacheData,
  output logic [DATA_W-1:0] ldData,
  output logic              ldFwd,
  output logic              ldPartial
);
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [BYTES-1:0]  beQ   [DEPTH];
  logic [BYTES-1:0]  covered;

  // Entry storage; one slot written per accepted store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
        beQ[i]   <= '0;
      end
    end else if (strobe.push) begin
      addrQ[wrPtr] <= stAddr;
      dataQ[wrPtr] <= stData;
      beQ[wrPtr]   <= stBe;
    end
  end

  assign dnAddr = addrQ[rdPtr];
  assign dnData = dataQ[rdPtr];
  assign dnBe   = beQ[rdPtr];

  // Walk entries oldest to youngest so a younger match overwrites an older one
  always_comb begin
    ldData  = cacheData;
    covered = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] slot;
      slot = PTR_W'((int'(rdPtr) + k) % DEPTH);
      if ((CNT_W'(k) < count) && (addrQ[slot] == ldAddr)) begin
        for (int b = 0; b < BYTES; b++) begin
          if (beQ[slot][b]) begin
            ldData[8*b +: 8] = dataQ[slot][8*b +: 8];
            covered[b]       = 1'b1;
          end
        end
      end
    end
  end

  assign ldFwd     = &covered;
  assign ldPartial = (|covered) && !(&covered);
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
  import store_wbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BYTES = DATA_W / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BYTES-1:0]  stBe,
  output logic              stReady,
  output logic              dnValid,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnData,
  output logic [BYTES-1:0]  dnBe,
  input  logic              dnReady,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] cacheData,
  output logic [DATA_W-1:0] ldData,
  output logic              ldFwd,
  output logic              ldPartial
);
  wbufStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  store_wbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .dnReady(dnReady),
    .stReady(stReady), .dnValid(dnValid), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .count(count)
  );

  store_wbuf_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .count(count), .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .dnAddr(dnAddr), .dnData(dnData), .dnBe(dnBe),
    .ldAddr(ldAddr), .cacheData(cacheData), .ldData(ldData),
    .ldFwd(ldFwd), .ldPartial(ldPartial)
  );
endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BYTES = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              dnValid,
  input logic [ADDR_W-1:0] dnAddr,
  input logic [DATA_W-1:0] dnData,
  input logic [BYTES-1:0]  dnBe,
  input logic              dnReady,
  input logic [DATA_W-1:0] cacheData,
  input logic [DATA_W-1:0] ldData,
  input logic              ldFwd,
  input logic              ldPartial
);
  // Occupancy rebuilt from the port handshakes alone
  logic [CNT_W-1:0] shadowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowCnt <= '0;
    else shadowCnt <= shadowCnt + CNT_W'(stValid && stReady) - CNT_W'(dnValid && dnReady);
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCnt == CNT_W'(DEPTH)) |-> !stReady);
  // R2
  room_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCnt < CNT_W'(DEPTH)) |-> stReady);
  // R3
  pending_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCnt != '0) |-> dnValid);
  // R3
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCnt == '0) |-> !dnValid);
  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnAddr) && $stable(dnData) && $stable(dnBe)));
  // R5
  empty_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCnt == '0) |-> (ldData == cacheData && !ldFwd && !ldPartial));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ldFwd && ldPartial));
endmodule

bind store_wbuf store_wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
  .dnValid(dnValid), .dnAddr(dnAddr), .dnData(dnData), .dnBe(dnBe),
  .dnReady(dnReady), .cacheData(cacheData), .ldData(ldData),
  .ldFwd(ldFwd), .ldPartial(ldPartial)
);

// File: tb/store_wbuf_tb_top.sv
module store_wbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stValid = 1'b0;
  logic [AW-1:0] stAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [3:0]    stBe = '0;
  logic          stReady;
  logic          dnValid;
  logic [AW-1:0] dnAddr;
  logic [DW-1:0] dnData;
  logic [3:0]    dnBe;
  logic          dnReady = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [DW-1:0] cacheData = '0;
  logic [DW-1:0] ldData;
  logic          ldFwd;
  logic          ldPartial;

  int checks = 0;
  int fails = 0;

  // Reference queue of pending stores, oldest first
  logic [AW-1:0] qA[$];
  logic [DW-1:0] qD[$];
  logic [3:0]    qB[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_wbuf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stBe(stBe), .stReady(stReady), .dnValid(dnValid), .dnAddr(dnAddr),
    .dnData(dnData), .dnBe(dnBe), .dnReady(dnReady), .ldAddr(ldAddr),
    .cacheData(cacheData), .ldData(ldData), .ldFwd(ldFwd), .ldPartial(ldPartial)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void expLoad(input logic [AW-1:0] a, input logic [DW-1:0] c,
                                  output logic [DW-1:0] d, output logic f, output logic p);
    logic [3:0] cov = '0;
    d = c;
    for (int i = 0; i < qA.size(); i++)
      if (qA[i] == a)
        for (int b = 0; b < 4; b++)
          if (qB[i][b]) begin
            d[8*b +: 8] = qD[i][8*b +: 8];
            cov[b] = 1'b1;
          end
    f = &cov;
    p = (|cov) && !(&cov);
  endfunction

  // One cycle: drive after the falling edge, check, then update the model at the rising edge
  task automatic step(input logic sv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] be, input logic dr, input logic [AW-1:0] la,
                      input logic [DW-1:0] lc, input string tag);
    logic [DW-1:0] eD;
    logic eF, eP, accept, drain;
    @(negedge clk);
    stValid = sv; stAddr = a; stData = d; stBe = be; dnReady = dr;
    ldAddr = la; cacheData = lc;
    #1;
    expLoad(la, lc, eD, eF, eP);
    chk(stReady == (qA.size() < DEPTH), tag, "stReady", 64'(stReady), 64'(qA.size() < DEPTH));
    chk(dnValid == (qA.size() > 0), tag, "dnValid", 64'(dnValid), 64'(qA.size() > 0));
    if (qA.size() > 0) begin
      chk(dnAddr == qA[0] && dnData == qD[0] && dnBe == qB[0], tag, "head",
          {dnAddr, dnData, 4'h0, dnBe}, {qA[0], qD[0], 4'h0, qB[0]});
    end
    chk(ldData == eD, tag, "ldData", 64'(ldData), 64'(eD));
    chk(ldFwd == eF && ldPartial == eP, tag, "ldFwd/ldPartial",
        64'({ldFwd, ldPartial}), 64'({eF, eP}));
    accept = sv && (qA.size() < DEPTH);
    drain  = dr && (qA.size() > 0);
    @(posedge clk);
    if (drain) begin
      void'(qA.pop_front()); void'(qD.pop_front()); void'(qB.pop_front());
    end
    if (accept) begin
      qA.push_back(a); qD.push_back(d); qB.push_back(be);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] ref0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step(0, 0, 0, 0, 0, 8'h05, 32'hCAFE_0001, "R1");

    // R6: full-word store forwards all lanes; R7: younger half-word overrides low lanes
    step(1, 8'h05, 32'h1111_1111, 4'hF, 0, 8'h05, 32'hAAAA_AAAA, "R5");
    step(1, 8'h05, 32'h2222_2222, 4'h3, 0, 8'h05, 32'hAAAA_AAAA, "R6");
    step(1, 8'h09, 32'h3333_3333, 4'h4, 0, 8'h05, 32'hAAAA_AAAA, "R7");
    // R8: only lane 2 of address 9 pending
    step(0, 0, 0, 0, 0, 8'h09, 32'hBBBB_BBBB, "R8");
    // R5: unmatched address passes cache data
    step(0, 0, 0, 0, 0, 8'h07, 32'hCCCC_CCCC, "R5");
    // R2: fill to DEPTH, then an extra store is refused
    step(1, 8'h0A, 32'h4444_4444, 4'hF, 0, 8'h0A, 32'h0, "R2");
    step(1, 8'h0B, 32'h5555_5555, 4'hF, 0, 8'h0B, 32'h0, "R2");
    step(1, 8'h0B, 32'h6666_6666, 4'hF, 0, 8'h0B, 32'h0, "R2");
    // R3: hold head while dnReady low, then drain one in order; refused store stays out
    step(0, 0, 0, 0, 0, 8'h05, 32'h0, "R3");
    // R9: head drains this cycle but still forwards during it
    step(0, 0, 0, 0, 1, 8'h05, 32'hDDDD_DDDD, "R9");
    // R4: accept and drain together with 3 pending, then one more fills
    step(1, 8'h0C, 32'h7777_7777, 4'hF, 1, 8'h0C, 32'h0, "R4");
    step(1, 8'h0D, 32'h8888_8888, 4'hF, 0, 8'h0D, 32'h0, "R4");
    step(1, 8'h0E, 32'h9999_9999, 4'hF, 0, 8'h0E, 32'h0, "R4");
    // R3: drain everything in order
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 8'h0C, 32'hEEEE_EEEE, "R3");
    // R9: drained entries no longer forward
    step(0, 0, 0, 0, 0, 8'h05, 32'h1234_5678, "R9");
    step(0, 0, 0, 0, 0, 8'h0B, 32'h1234_5678, "R9");

    // Near-exhaustive sweep: every byte-enable pattern, colliding addresses
    for (int be = 0; be < 16; be++) begin
      for (int j = 0; j < 3; j++)
        step(1, 8'(j % 2), {8'(be), 8'(j), 8'(be), 8'(j)} ^ 32'h5A5A_0000,
             4'(be + j), 0, 8'(j % 2), 32'hF0F0_F0F0, "R7");
      for (int la = 0; la < 3; la++) step(0, 0, 0, 0, 0, 8'(la), 32'h0F0F_0F0F, "R6");
      for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 8'(k % 2), 32'h3C3C_3C3C, "R9");
    end

    // Random traffic over a small address range
    for (int n = 0; n < 3000; n++) begin
      ref0 = $urandom;
      step($urandom_range(0, 1) == 1, 8'($urandom_range(0, 3)), ref0, 4'($urandom),
           $urandom_range(0, 2) != 0, 8'($urandom_range(0, 4)), $urandom, "R8");
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 0, 0, "R3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule